// File: doc/BRIEF.md
# Codec Immediate Command and Response Registers

This block gives software a single-shot path for sending one 32-bit command word to an audio codec and collecting the answer. Software loads the command word into a read/write register and then writes 1 to a busy bit in the status register. The block captures the word, offers it to the link side through a valid/ready handshake, and then waits for a response strobe. When the response arrives, it is latched into a read-only response register. In the same update the busy bit returns to 0 and a sticky valid flag rises. Software clears the valid flag by writing 1 to it.

The link side sees a command port (`cmd_valid`, `cmd_ready`, `cmd_data`) and a response port (`rsp_strobe`, `rsp_data`). Serialization, codec addressing and queued command rings sit outside this block.

The sequencer has three states:
- `ST_IDLE`: busy reads 0. A busy write of 1 takes the transition *issue* to `ST_SEND`.
- `ST_SEND`: the captured command is offered. An accepted handshake takes the transition *accept* to `ST_WAIT`.
- `ST_WAIT`: a response strobe takes the transition *complete* back to `ST_IDLE`.

All other events keep the current state.

Top module: `codec_imm_regs`

## Requirements
- R1: After reset, the command word, response word and status word all read 0, and `cmd_valid` is 0.
- R2: The command word at offset 0x60 is read/write. Write byte enable bit i updates bits 8i+7:8i only.
- R3: The response word at offset 0x64 ignores writes. Status bits 31:2 at offset 0x68 always read 0. Any other offset reads 0.
- R4: A status write with byte enable 0 set and data bit 0 = 1 while busy is 0 raises busy (status bit 0). From the next cycle it drives `cmd_valid` = 1 with the command word as it stood at that write.
- R5: `cmd_valid` stays 1 with stable `cmd_data` until a cycle with `cmd_ready` = 1. Exactly one transfer is made per issue.
- R6: A `rsp_strobe` after the transfer latches `rsp_data` into the response word. On the same edge it sets the valid flag (status bit 1) and clears busy.
- R7: Writing 1 to status bit 1 clears the valid flag. Writing 0 to it leaves the flag unchanged.
- R8: While busy is 1, a status write of 1 to bit 0 makes no second transfer, and a write of 0 to bit 0 does not clear busy.
- R9: A `rsp_strobe` while busy is 0, or before the command transfer has completed, changes neither the response word nor the valid flag.
- R10: When a response capture and a software clear of the valid flag fall on the same edge, the valid flag ends at 1.
- R11: Writes to the command word while busy is 1 do not change the `cmd_data` being offered.
- R12: A status write with byte enable 0 clear has no effect on busy or valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Write byte enables |
| bus_rdata | output | DATA_W | Read data, combinational from address while `bus_rd` is 1, else 0 |
| cmd_valid | output | 1 | Command offered to link side |
| cmd_ready | input | 1 | Link side accepts the command |
| cmd_data | output | DATA_W | Captured command word |
| rsp_strobe | input | 1 | One-cycle response arrival |
| rsp_data | input | DATA_W | Response word |

## Verification
The bound checker watches the following on every cycle:
- the command handshake holding with stable data (R5);
- busy being held until a response completes (R8);
- the response word moving only on an accepted strobe (R9);
- the completion update setting valid as busy falls (R6, R10);
- a lone software clear dropping valid (R7);
- reserved status bits reading 0 (R3).

Some behaviours depend on chosen stimulus order, so only the bench's scenarios can show them:
- byte-enable merging (R2);
- the command snapshot surviving later writes (R11);
- the exact count of transfers per issue (R5);
- strobes dropped in `ST_IDLE` and `ST_SEND` (R9);
- the same-edge race between a strobe and a clear write (R10).

// File: rtl/codec_imm_pkg.sv
package codec_imm_pkg;

    // Register byte offsets; software depends on these.
    localparam int unsigned CMD_OFFSET  = 32'h60;
    localparam int unsigned RSP_OFFSET  = 32'h64;
    localparam int unsigned STAT_OFFSET = 32'h68;

    // Status bit positions.
    localparam int unsigned STAT_BUSY_BIT  = 0;
    localparam int unsigned STAT_VALID_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } imm_state_e;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_CMD  = 2'd1,
        RSEL_RSP  = 2'd2,
        RSEL_STAT = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/imm_bus_decode.sv
module imm_bus_decode
    import codec_imm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NBYTES = DATA_W / 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NBYTES-1:0] bus_be,
    output logic [NBYTES-1:0] cmd_byte_we,
    output logic              go_req,
    output logic              clr_req,
    output rd_sel_e           rd_sel
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFFSET);
    localparam logic [ADDR_W-1:0] A_RSP  = ADDR_W'(RSP_OFFSET);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFFSET);

    logic hit_cmd;
    logic hit_rsp;
    logic hit_stat;
    logic stat_wr;

    always_comb begin
        hit_cmd  = (bus_addr == A_CMD);
        hit_rsp  = (bus_addr == A_RSP);
        hit_stat = (bus_addr == A_STAT);
        stat_wr  = bus_wr && hit_stat && bus_be[0];
    end

    // Per-byte command write enables.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_we
        assign cmd_byte_we[b] = bus_wr && hit_cmd && bus_be[b];
    end

    always_comb begin
        go_req  = stat_wr && bus_wdata[STAT_BUSY_BIT];
        clr_req = stat_wr && bus_wdata[STAT_VALID_BIT];
    end

    always_comb begin
        rd_sel = RSEL_NONE;
        if (bus_rd) begin
            if (hit_cmd)       rd_sel = RSEL_CMD;
            else if (hit_rsp)  rd_sel = RSEL_RSP;
            else if (hit_stat) rd_sel = RSEL_STAT;
        end
    end

endmodule

// File: rtl/imm_cmd_reg.sv
module imm_cmd_reg #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_q
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[8*b +: 8] <= '0;
            end else if (byte_we[b]) begin
                word_q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/imm_seq.sv
module imm_seq
    import codec_imm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic              cmd_ready,
    input  logic              rsp_strobe,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              capture
);

    imm_state_e        state_q;
    imm_state_e        state_d;
    logic [DATA_W-1:0] snap_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: issue, accept, complete.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_req)     state_d = ST_SEND;
            ST_SEND: if (cmd_ready)  state_d = ST_WAIT;
            ST_WAIT: if (rsp_strobe) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        cmd_valid = 1'b0;
        busy      = 1'b1;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy      = 1'b0;
            ST_SEND: cmd_valid = 1'b1;
            ST_WAIT: capture   = rsp_strobe;
            default: busy      = 1'b0;
        endcase
    end

    // Command snapshot taken on the issue transition only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (state_q == ST_IDLE && go_req) begin
            snap_q <= cmd_word;
        end
    end

    assign cmd_data = snap_q;

endmodule

// File: rtl/imm_rsp_capture.sv
module imm_rsp_capture #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              clr_req,
    output logic [DATA_W-1:0] resp_q,
    output logic              rv_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (capture) begin
            resp_q <= rsp_data;
        end
    end

    // Hardware set has priority over the software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
        end else if (capture) begin
            rv_q <= 1'b1;
        end else if (clr_req) begin
            rv_q <= 1'b0;
        end
    end

endmodule

// File: rtl/codec_imm_regs.sv
module codec_imm_regs
    import codec_imm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NBYTES-1:0] bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              rsp_strobe,
    input  logic [DATA_W-1:0] rsp_data
);

    logic [NBYTES-1:0] cmd_byte_we;
    logic              go_req;
    logic              clr_req;
    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] cmd_word;
    logic              busy;
    logic              capture;
    logic [DATA_W-1:0] resp_q;
    logic              rv_q;
    logic [DATA_W-1:0] stat_word;

    imm_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_be      (bus_be),
        .cmd_byte_we (cmd_byte_we),
        .go_req      (go_req),
        .clr_req     (clr_req),
        .rd_sel      (rd_sel)
    );

    imm_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (cmd_byte_we),
        .wdata   (bus_wdata),
        .word_q  (cmd_word)
    );

    imm_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_req     (go_req),
        .cmd_word   (cmd_word),
        .cmd_ready  (cmd_ready),
        .rsp_strobe (rsp_strobe),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .busy       (busy),
        .capture    (capture)
    );

    imm_rsp_capture #(.DATA_W(DATA_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .rsp_data (rsp_data),
        .clr_req  (clr_req),
        .resp_q   (resp_q),
        .rv_q     (rv_q)
    );

    always_comb begin
        stat_word                 = '0;
        stat_word[STAT_BUSY_BIT]  = busy;
        stat_word[STAT_VALID_BIT] = rv_q;
    end

    always_comb begin
        unique case (rd_sel)
            RSEL_CMD:  bus_rdata = cmd_word;
            RSEL_RSP:  bus_rdata = resp_q;
            RSEL_STAT: bus_rdata = stat_word;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/codec_imm_checker.sv
module codec_imm_checker
    import codec_imm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] cmd_data,
    input logic              rsp_strobe,
    input logic              busy,
    input logic              clr_req,
    input logic [DATA_W-1:0] resp_q,
    input logic              rv_q
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFFSET);

    logic waiting;
    assign waiting = busy && !cmd_valid;

    assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    assert_offer_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    assert_complete_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rsp_strobe |=> !busy && rv_q);

    assert_busy_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(waiting && rsp_strobe) |=> busy);

    assert_drop_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(waiting && rsp_strobe) |=> $stable(resp_q));

    assert_clear_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !(waiting && rsp_strobe) |=> !rv_q);

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && waiting && rsp_strobe |=> rv_q);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == A_STAT |-> bus_rdata[DATA_W-1:2] == '0);

endmodule

bind codec_imm_regs codec_imm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_data   (cmd_data),
    .rsp_strobe (rsp_strobe),
    .busy       (busy),
    .clr_req    (clr_req),
    .resp_q     (resp_q),
    .rv_q       (rv_q)
);

// File: tb/tb_codec_imm_regs.sv
module tb_codec_imm_regs;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [3:0]        bus_be = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [DATA_W-1:0] cmd_data;
    logic              rsp_strobe = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int xfers = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    codec_imm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .rsp_strobe(rsp_strobe), .rsp_data(rsp_data)
    );

    always @(posedge clk) if (rst_n && cmd_valid && cmd_ready) xfers <= xfers + 1;

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h60, 32'hDEADBEEF, 4'hF, 32'h0,        8'd2},  // R2 full write
        '{1'b0, 8'h60, 32'h0,        4'h0, 32'hDEADBEEF, 8'd2},  // R2
        '{1'b1, 8'h60, 32'h11223344, 4'h5, 32'h0,        8'd2},  // R2 lanes 0,2
        '{1'b0, 8'h60, 32'h0,        4'h0, 32'hDE22BE44, 8'd2},  // R2
        '{1'b1, 8'h64, 32'hFFFFFFFF, 4'hF, 32'h0,        8'd3},  // R3 write ignored
        '{1'b0, 8'h64, 32'h0,        4'h0, 32'h0,        8'd3},  // R3
        '{1'b1, 8'h68, 32'hFFFFFFFC, 4'hF, 32'h0,        8'd3},  // R3 reserved
        '{1'b0, 8'h68, 32'h0,        4'h0, 32'h0,        8'd3},  // R3
        '{1'b0, 8'h20, 32'h0,        4'h0, 32'h0,        8'd3},  // R3 unmapped
        '{1'b1, 8'h68, 32'h00000003, 4'h0, 32'h0,        8'd12}, // R12 be0 clear
        '{1'b0, 8'h68, 32'h0,        4'h0, 32'h0,        8'd12}  // R12
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_rsp(input logic [31:0] d);
        rsp_data = d; rsp_strobe = 1'b1;
        tick();
        rsp_strobe = 1'b0;
    endtask

    task automatic issue_and_accept(input logic [31:0] w);
        bwrite(8'h60, w, 4'hF);
        bwrite(8'h68, 32'h1, 4'h1);
        cmd_ready = 1'b1;
        tick();
        cmd_ready = 1'b0;
    endtask

    logic [31:0] rd;
    int x0;

    initial begin
        repeat (3) tick();
        // R1 reset state
        bread(8'h60, rd); chk("R1 cmd", rd, 32'h0);
        bread(8'h64, rd); chk("R1 rsp", rd, 32'h0);
        bread(8'h68, rd); chk("R1 stat", rd, 32'h0);
        chk("R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                bwrite(VECS[i].addr, VECS[i].data, VECS[i].be);
            end else begin
                bread(VECS[i].addr, rd);
                chk($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        chk("R12 no issue", {31'b0, cmd_valid}, 32'h0);

        // R4 issue
        bwrite(8'h60, 32'hA5A50001, 4'hF);
        bwrite(8'h68, 32'h1, 4'h1);
        chk("R4 cmd_valid", {31'b0, cmd_valid}, 32'h1);
        chk("R4 cmd_data", cmd_data, 32'hA5A50001);
        bread(8'h68, rd); chk("R4 busy", rd, 32'h1);
        // R11 snapshot
        bwrite(8'h60, 32'h12345678, 4'hF);
        chk("R11 cmd_data", cmd_data, 32'hA5A50001);
        // R8 while offering
        bwrite(8'h68, 32'h0, 4'h1);
        bread(8'h68, rd); chk("R8 write0", rd, 32'h1);
        // R9 strobe before transfer
        pulse_rsp(32'h00000BAD);
        bread(8'h64, rd); chk("R9 send rsp", rd, 32'h0);
        bread(8'h68, rd); chk("R9 send stat", rd, 32'h1);
        // R5 hold then accept
        repeat (3) tick();
        chk("R5 hold", {31'b0, cmd_valid}, 32'h1);
        chk("R5 data", cmd_data, 32'hA5A50001);
        cmd_ready = 1'b1;
        tick();
        cmd_ready = 1'b0;
        chk("R5 drop", {31'b0, cmd_valid}, 32'h0);
        chk("R5 one xfer", xfers, 1);
        // R8 write 1 while waiting
        bwrite(8'h68, 32'h1, 4'h1);
        cmd_ready = 1'b1;
        repeat (2) tick();
        cmd_ready = 1'b0;
        chk("R8 no reissue", xfers, 1);
        // R6 completion
        pulse_rsp(32'hCAFE0001);
        bread(8'h64, rd); chk("R6 rsp", rd, 32'hCAFE0001);
        bread(8'h68, rd); chk("R6 stat", rd, 32'h2);
        // R7
        bwrite(8'h68, 32'h0, 4'h1);
        bread(8'h68, rd); chk("R7 write0", rd, 32'h2);
        bwrite(8'h68, 32'h2, 4'h1);
        bread(8'h68, rd); chk("R7 clear", rd, 32'h0);
        // R9 idle strobe
        pulse_rsp(32'h00000055);
        bread(8'h64, rd); chk("R9 idle rsp", rd, 32'hCAFE0001);
        bread(8'h68, rd); chk("R9 idle stat", rd, 32'h0);
        // R5 ready held high: one transfer only
        x0 = xfers;
        cmd_ready = 1'b1;
        bwrite(8'h60, 32'h0000F00D, 4'hF);
        bwrite(8'h68, 32'h1, 4'h1);
        repeat (4) tick();
        cmd_ready = 1'b0;
        chk("R5 ready high", xfers - x0, 1);
        // R10 capture and clear on the same edge
        bus_addr = 8'h68; bus_wdata = 32'h2; bus_be = 4'h1; bus_wr = 1'b1;
        rsp_data = 32'h0BADF00D; rsp_strobe = 1'b1;
        tick();
        bus_wr = 1'b0; bus_be = '0; rsp_strobe = 1'b0;
        bread(8'h68, rd); chk("R10 set wins", rd, 32'h2);
        bread(8'h64, rd); chk("R6 rsp2", rd, 32'h0BADF00D);
        // R4 snapshot of a fresh word
        bwrite(8'h68, 32'h2, 4'h1);
        issue_and_accept(32'h77665544);
        chk("R4 xfer count", xfers - x0, 2);
        pulse_rsp(32'h1);
        bread(8'h68, rd); chk("R6 stat2", rd, 32'h2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule